// File: doc/BRIEF.md
# UART Receive Line-Condition Event Detector

This block sits beside a UART receiver core and turns its per-bit framing strobes into sticky line-condition events. The receiver marks every bit-centre sample with `bit_stb` and gives the sampled level on `rx_bit`. It also marks the start-bit and stop-bit centres, and it pulses `close_req` while a character that ends a receive buffer is being framed. From these inputs the block tracks a live idle status and detects the start and end of a break sequence. It also times the buffer-complete event so that it falls on the stop-bit centre of the closing character.

Four event bits are kept in a register that is set by hardware and cleared by writing ones on `clr_we`/`clr_bits`. A mask register, loaded through `mask_we`/`mask_bits`, selects which events drive `irq`. The idle detector uses hysteresis. It needs a full frame's worth of one samples (`FRAME_BITS`) to declare the line idle, and a single zero sample drops it.

Top module: `uart_rx_line_events`

## Requirements
- R1: `idle_live` rises after `FRAME_BITS` consecutive `bit_stb` samples with `rx_bit`=1. It is visible on the cycle after the last of those samples.
- R2: Any `bit_stb` sample with `rx_bit`=0 clears `idle_live` on the next cycle.
- R3: Each change of `idle_live`, entering or leaving idle, sets event bit 0 (idle change).
- R4: A break frame sets event bit 1 (break start) only when no break sequence is already in progress. Further break frames in the same sequence leave it clear. A break frame is one whose start, data and stop samples are all 0.
- R5: The first `bit_stb` sample with `rx_bit`=1 after a break sequence sets event bit 2 (break end) and ends the sequence.
- R6: Event bit 3 (buffer complete) is set on the cycle after the `stop_stb` of a frame during which `close_req` was pulsed, and at no other time.
- R7: A frame with all-zero data whose stop sample is 1 is not a break and sets neither bit 1 nor bit 2.
- R8: Event bits are sticky. A one in `clr_bits` with `clr_we` clears that bit, other bits are kept, and a set on the same cycle wins over the clear.
- R9: `irq` is high exactly when some event bit and its mask bit are both 1.
- R10: Reset clears all event bits, the mask, `idle_live` and the break-in-progress state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Sampled line level, valid with `bit_stb` |
| bit_stb | input | 1 | Bit-centre sample strobe |
| start_stb | input | 1 | Marks the start-bit sample (with `bit_stb`) |
| stop_stb | input | 1 | Marks the stop-bit sample (with `bit_stb`) |
| close_req | input | 1 | The current frame closes a receive buffer |
| clr_we | input | 1 | Apply write-one-to-clear of events |
| clr_bits | input | 4 | Event bits to clear |
| mask_we | input | 1 | Load the interrupt mask |
| mask_bits | input | 4 | New interrupt mask |
| ev_flags | output | 4 | Sticky events: 0 idle change, 1 break start, 2 break end, 3 buffer complete |
| idle_live | output | 1 | Live idle status |
| irq | output | 1 | Masked OR of events |

## Verification
The bench builds the block with `FRAME_BITS` = 4, one start bit, two data bits and one stop bit. This keeps idle entry, break frames and ordinary frames only a few strobes long. A run of ones can then be cut one sample short of the idle threshold and then completed, and two break frames can be chained into one sequence. Set-versus-clear collisions on the same cycle and a reset in the middle of a break sequence can be reached in a few dozen cycles.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    localparam int EV_W = 4;

    typedef enum int {
        EV_IDLE_CHG  = 0,
        EV_BRK_START = 1,
        EV_BRK_END   = 2,
        EV_RXBUF     = 3
    } ev_idx_e;

    typedef logic [EV_W-1:0] ev_vec_t;

    typedef struct packed {
        logic rxbuf;
        logic brk_end;
        logic brk_start;
        logic idle_chg;
    } ev_hits_t;

    typedef struct packed {
        logic rx;
        logic bit_s;
        logic start_s;
        logic stop_s;
    } line_smp_t;

    function automatic ev_vec_t w1c_apply(ev_vec_t cur, ev_vec_t clr, logic we, ev_vec_t set);
        ev_vec_t kept;
        kept = we ? (cur & ~clr) : cur;
        return kept | set;
    endfunction

endpackage

// File: rtl/uart_idle_tracker.sv
module uart_idle_tracker
    import uart_evt_pkg::*;
#(
    parameter int FRAME_BITS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  line_smp_t smp,
    output logic      idle,
    output logic      idle_chg
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic [CW-1:0] ones_cnt;
    logic          enter_now;
    logic          leave_now;

    always_comb begin
        enter_now = smp.bit_s && smp.rx && !idle && (ones_cnt == LAST);
        leave_now = smp.bit_s && !smp.rx && idle;
        idle_chg  = enter_now || leave_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt <= '0;
            idle     <= 1'b0;
        end else if (smp.bit_s) begin
            if (!smp.rx) begin
                ones_cnt <= '0;
                idle     <= 1'b0;
            end else begin
                if (ones_cnt != CW'(FRAME_BITS))
                    ones_cnt <= ones_cnt + 1'b1;
                if (enter_now)
                    idle <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor
    import uart_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_smp_t smp,
    input  logic      close_req,
    output logic      brk_start,
    output logic      brk_end,
    output logic      rxbuf_done
);
    logic in_frame;
    logic all_zero;
    logic in_break;
    logic close_pend;
    logic frame_end;
    logic is_break;

    always_comb begin
        frame_end  = smp.bit_s && smp.stop_s && in_frame;
        is_break   = frame_end && all_zero && !smp.rx;
        brk_start  = is_break && !in_break;
        brk_end    = smp.bit_s && smp.rx && in_break;
        rxbuf_done = smp.bit_s && smp.stop_s && (close_pend || close_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            all_zero   <= 1'b0;
            in_break   <= 1'b0;
            close_pend <= 1'b0;
        end else begin
            if (smp.bit_s && smp.start_s) begin
                in_frame <= 1'b1;
                all_zero <= !smp.rx;
            end else if (frame_end) begin
                in_frame <= 1'b0;
            end else if (smp.bit_s && in_frame) begin
                all_zero <= all_zero && !smp.rx;
            end

            if (brk_end)
                in_break <= 1'b0;
            else if (is_break)
                in_break <= 1'b1;

            if (smp.bit_s && smp.stop_s)
                close_pend <= 1'b0;
            else if (close_req)
                close_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_event_reg.sv
module uart_event_reg
    import uart_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ev_hits_t hits,
    input  logic     clr_we,
    input  ev_vec_t  clr_bits,
    input  logic     mask_we,
    input  ev_vec_t  mask_bits,
    output ev_vec_t  flags,
    output logic     irq
);
    ev_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            mask_q <= '0;
        end else begin
            flags <= w1c_apply(flags, clr_bits, clr_we, ev_vec_t'(hits));
            if (mask_we)
                mask_q <= mask_bits;
        end
    end

    always_comb irq = |(flags & mask_q);
endmodule

// File: rtl/uart_rx_line_events.sv
module uart_rx_line_events
    import uart_evt_pkg::*;
#(
    parameter int FRAME_BITS = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_bit,
    input  logic            bit_stb,
    input  logic            start_stb,
    input  logic            stop_stb,
    input  logic            close_req,
    input  logic            clr_we,
    input  logic [EV_W-1:0] clr_bits,
    input  logic            mask_we,
    input  logic [EV_W-1:0] mask_bits,
    output logic [EV_W-1:0] ev_flags,
    output logic            idle_live,
    output logic            irq
);
    line_smp_t smp;
    ev_hits_t  hits;
    logic      idle_chg, brk_s, brk_e, rxbuf;

    always_comb begin
        smp.rx      = rx_bit;
        smp.bit_s   = bit_stb;
        smp.start_s = start_stb;
        smp.stop_s  = stop_stb;
        hits.idle_chg  = idle_chg;
        hits.brk_start = brk_s;
        hits.brk_end   = brk_e;
        hits.rxbuf     = rxbuf;
    end

    uart_idle_tracker #(.FRAME_BITS(FRAME_BITS)) u_idle (
        .clk(clk), .rst(rst), .smp(smp), .idle(idle_live), .idle_chg(idle_chg)
    );

    uart_frame_monitor u_frame (
        .clk(clk), .rst(rst), .smp(smp), .close_req(close_req),
        .brk_start(brk_s), .brk_end(brk_e), .rxbuf_done(rxbuf)
    );

    uart_event_reg u_evreg (
        .clk(clk), .rst(rst), .hits(hits), .clr_we(clr_we), .clr_bits(clr_bits),
        .mask_we(mask_we), .mask_bits(mask_bits), .flags(ev_flags), .irq(irq)
    );
endmodule

// File: rtl/uart_rx_line_events_chk.sv
module uart_rx_line_events_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_bit,
    input logic       bit_stb,
    input logic       stop_stb,
    input logic       clr_we,
    input logic [3:0] clr_bits,
    input logic [3:0] ev_flags,
    input logic       idle_live,
    input logic       irq
);
    // R2
    a_r2_zero_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !rx_bit) |=> !idle_live);
    // R3
    a_r3_idle_move_flags: assert property (@(posedge clk) disable iff (rst)
        (idle_live != $past(idle_live)) |-> ev_flags[0]);
    // R4
    a_r4_brk_start_at_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_flags[1]) |-> $past(stop_stb && bit_stb && !rx_bit));
    // R5
    a_r5_brk_end_on_one: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_flags[2]) |-> $past(bit_stb && rx_bit));
    // R6
    a_r6_rxbuf_at_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_flags[3]) |-> $past(stop_stb && bit_stb));
    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((ev_flags & $past(ev_flags)) == $past(ev_flags)));
    // R9
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_flags != 4'b0));
    // R10
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (ev_flags == 4'b0 && !idle_live && !irq));
endmodule

bind uart_rx_line_events uart_rx_line_events_chk u_chk (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_stb(bit_stb), .stop_stb(stop_stb),
    .clr_we(clr_we), .clr_bits(clr_bits), .ev_flags(ev_flags),
    .idle_live(idle_live), .irq(irq)
);

// File: tb/uart_rx_line_events_test.sv
module uart_rx_line_events_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b1, bit_stb = 1'b0, start_stb = 1'b0, stop_stb = 1'b0;
    logic       close_req = 1'b0, clr_we = 1'b0, mask_we = 1'b0;
    logic [3:0] clr_bits = 4'h0, mask_bits = 4'h0;
    logic [3:0] ev_flags;
    logic       idle_live, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uart_rx_line_events #(.FRAME_BITS(4)) uut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_stb(bit_stb),
        .start_stb(start_stb), .stop_stb(stop_stb), .close_req(close_req),
        .clr_we(clr_we), .clr_bits(clr_bits), .mask_we(mask_we),
        .mask_bits(mask_bits), .ev_flags(ev_flags), .idle_live(idle_live), .irq(irq)
    );

    // {rx, start, stop, close, exp_idle, exp_flags[3:0]}
    localparam int NV = 26;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_0_0_0_0000, 9'b1_0_0_0_0_0000, 9'b1_0_0_0_0_0000, // R1 run below threshold
        9'b1_0_0_0_1_0001,                                       // R1 R3 enter idle
        9'b1_0_0_0_1_0000,
        9'b0_1_0_0_0_0001,                                       // R2 R3 leave on zero
        9'b0_0_0_1_0_0000, 9'b0_0_0_0_0_0000,
        9'b0_0_1_0_0_1010,                                       // R4 R6 break start + buffer
        9'b0_1_0_0_0_0000, 9'b0_0_0_0_0_0000, 9'b0_0_0_0_0_0000,
        9'b0_0_1_0_0_0000,                                       // R4 second break silent
        9'b1_0_0_0_0_0100,                                       // R5 break end
        9'b1_0_0_0_0_0000, 9'b1_0_0_0_0_0000,
        9'b1_0_0_0_1_0001,                                       // R1 idle again
        9'b0_1_0_0_0_0001,
        9'b1_0_0_1_0_0000, 9'b1_0_0_0_0_0000,
        9'b1_0_1_0_0_1000,                                       // R6 normal frame closes
        9'b1_0_0_0_1_0001,                                       // R1 run spans the frame
        9'b0_1_0_0_0_0001,
        9'b0_0_0_0_0_0000, 9'b0_0_0_0_0_0000,
        9'b1_0_1_0_0_0000                                        // R7 stop high, no break
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic rx, input logic st, input logic sp, input logic cl);
        @(negedge clk);
        rx_bit = rx; bit_stb = 1'b1; start_stb = st; stop_stb = sp; close_req = cl;
        @(negedge clk);
        bit_stb = 1'b0; start_stb = 1'b0; stop_stb = 1'b0; close_req = 1'b0;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_bits = 4'hF;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = 4'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 flags", int'(ev_flags), 0);
        chk("R10 idle", int'(idle_live), 0);
        chk("R10 irq", int'(irq), 0);

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            chk($sformatf("R1-table idle step %0d", i), int'(idle_live), int'(VEC[i][4]));
            chk($sformatf("R3 table flags step %0d", i), int'(ev_flags), int'(VEC[i][3:0]));
            clear_all();
        end

        // R8 set beats clear: one-run at 1, two more ones then the entering sample with a clear
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rx_bit = 1'b1; bit_stb = 1'b1; clr_we = 1'b1; clr_bits = 4'h1;
        @(negedge clk);
        bit_stb = 1'b0; clr_we = 1'b0; clr_bits = 4'h0;
        chk("R8 set wins", int'(ev_flags), 1);
        chk("R1 idle via collision", int'(idle_live), 1);

        // R9 mask gating
        chk("R9 mask zero", int'(irq), 0);
        mask_we = 1'b1; mask_bits = 4'h1;
        @(negedge clk);
        mask_we = 1'b0;
        chk("R9 masked on", int'(irq), 1);
        mask_we = 1'b1; mask_bits = 4'hE;
        @(negedge clk);
        mask_we = 1'b0;
        chk("R9 other bits", int'(irq), 0);

        // R10 reset mid-break
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 break start", int'(ev_flags[1]), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 flags after reset", int'(ev_flags), 0);
        chk("R10 idle after reset", int'(idle_live), 0);
        chk("R10 irq after reset", int'(irq), 0);
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
        strobe(1'b0, 1'b0, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 break state cleared, R4 fresh start", int'(ev_flags), 4'hA);
        chk("R10 mask cleared", int'(irq), 0);

        // R8 partial clear keeps other bits
        clr_we = 1'b1; clr_bits = 4'h2;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = 4'h0;
        chk("R8 partial clear", int'(ev_flags), 4'h8);
        @(negedge clk);
        chk("R8 sticky hold", int'(ev_flags), 4'h8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule